// File: doc/BRIEF.md
# Widescreen Signalling Bit Serializer

This block holds widescreen-signalling payloads for two video lines of a frame and sends each one, bit by bit, when the line counter reaches that line's target number. Each line has a 14-bit data value and a 6-bit check value. The host loads them through three separate byte writes: the low data byte, the upper six data bits and the check bits. The writes may arrive in any order. A line's registers change only when all three bytes have arrived within one frame. A partial set is dropped at the next frame boundary.

On a target line the block sends a fixed run-in pattern, then a start code, then the 14 data bits LSB first. In NTSC mode the 6 check bits follow, also LSB first. In PAL mode the transmission stops after the data bits. Each bit is held for a parameterized number of clock cycles and is presented as a level code. The code is 140 for a one in NTSC (70 IRE in half-IRE steps), 143 for a one in PAL (71.5 IRE), and 0 for a zero or when idle. A per-line status bit gives the host a handshake. It drops to 0 once a complete, enabled load has been accepted. It returns to 1 after that line has been sent. If the host writes nothing new, the stored values are sent again on the next target line.

Host writes use a valid/ready handshake. A write transfers on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` falls only while the addressed line is being sent, and the host must hold its write until ready returns. The serial output has no back-pressure: video timing is fixed, so `active`, `bit_out` and `lvl_code` are qualified by `active` alone.

Top module: `wss_serializer`

## Requirements
- R1: After reset both status bits are 1, `active` is 0, `lvl_code` is 0, `wr_ready` is 1, and the stored data and check values of both lines are 0.
- R2: A write with `wr_sel` 0 supplies data bits 7:0, `wr_sel` 1 supplies data bits 13:8 (from `wr_data[5:0]`), and `wr_sel` 2 supplies the check bits (from `wr_data[5:0]`). The three writes may come in any order. The stored values change only on the edge where the third distinct byte of the set is accepted.
- R3: A `frame_start` pulse discards any incomplete set of byte writes. A write accepted in the same cycle as the pulse counts toward the new set.
- R4: A transmission of line 0 starts in the cycle after a `line_start` pulse with `line_num` equal to LINE_A and `line_en[0]` high. Line 1 starts the same way with LINE_B and `line_en[1]`. Any other line number, or a disabled line, starts nothing.
- R5: A transmission sends the run-in pattern LSB first, then the start code LSB first, then the 14 data bits LSB first. Each bit is held for BIT_CYC cycles.
- R6: In NTSC mode (`std_ntsc` = 1, sampled at the start of the line), the 6 check bits follow the data bits LSB first. In PAL mode they are not sent.
- R7: While active, `lvl_code` is 140 for a one bit in NTSC, 143 for a one bit in PAL, and 0 for a zero bit. While idle it is 0.
- R8: A line's status bit goes to 0 on the edge where a complete set is accepted, but only while that line is enabled. It goes to 1 on the edge that ends that line's transmission.
- R9: Without new writes, a later target line sends the same stored values again.
- R10: `wr_ready` is low only while the line selected by `wr_line` is being sent. A write with `wr_sel` 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host byte write valid |
| wr_ready | output | 1 | Host byte write ready |
| wr_line | input | 1 | Line register set addressed (0 or 1) |
| wr_sel | input | 2 | Byte selector: 0 low data, 1 high data, 2 check, 3 none |
| wr_data | input | 8 | Write byte |
| frame_start | input | 1 | Frame boundary pulse |
| line_en | input | 2 | Per-line enable |
| line_start | input | 1 | Start-of-line pulse |
| line_num | input | 10 | Current line number |
| std_ntsc | input | 1 | 1 = NTSC, 0 = PAL |
| active | output | 1 | Transmission in progress |
| bit_out | output | 1 | Current serial bit |
| lvl_code | output | 8 | Output level code in half-IRE steps |
| status | output | 2 | Per-line status: 0 loaded, 1 sent or free |

## Verification
The serial stream is checked against a bit-by-bit expected sequence in several situations. These are reset values, a fresh NTSC load, the same values resent, a PAL send and a send of line 1. Together they separate the bit order, the presence of the check field and the level for each standard. Loads are made in several byte orders, and one load is interrupted by a frame boundary, so that a dropped partial set can be told apart from a completed one. A line that is disabled or has the wrong number must produce no output. Status and ready are sampled at the points where they must change and at the points where they must hold.

// File: rtl/wss_pkg.sv
package wss_pkg;
  localparam int DATA_W = 14;
  localparam int CHK_W  = 6;
  localparam int LO_W   = 8;
  localparam int HI_W   = DATA_W - LO_W;

  typedef enum logic [1:0] {
    SEL_LO   = 2'd0,
    SEL_HI   = 2'd1,
    SEL_CHK  = 2'd2,
    SEL_NONE = 2'd3
  } wss_sel_e;
endpackage

// File: rtl/wss_line_store.sv
module wss_line_store
  import wss_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [1:0]        wr_sel,
  input  logic [7:0]        wr_data,
  input  logic              frame_start,
  input  logic              enable,
  input  logic              sending,
  input  logic              send_done,
  output logic [DATA_W-1:0] data_q,
  output logic [CHK_W-1:0]  chk_q,
  output logic              status_q
);
  logic [LO_W-1:0]  pend_lo,  pend_lo_n;
  logic [HI_W-1:0]  pend_hi,  pend_hi_n;
  logic [CHK_W-1:0] pend_chk, pend_chk_n;
  logic [2:0]       mask,     mask_n;
  logic             complete;
  wss_sel_e         sel;

  assign sel = wss_sel_e'(wr_sel);

  always_comb begin
    mask_n     = frame_start ? 3'b000 : mask;
    pend_lo_n  = pend_lo;
    pend_hi_n  = pend_hi;
    pend_chk_n = pend_chk;
    if (wr_hit) begin
      case (sel)
        SEL_LO:  begin pend_lo_n  = wr_data;             mask_n[0] = 1'b1; end
        SEL_HI:  begin pend_hi_n  = wr_data[HI_W-1:0];   mask_n[1] = 1'b1; end
        SEL_CHK: begin pend_chk_n = wr_data[CHK_W-1:0];  mask_n[2] = 1'b1; end
        default: ;
      endcase
    end
    complete = &mask_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_lo  <= '0;
      pend_hi  <= '0;
      pend_chk <= '0;
      mask     <= '0;
      data_q   <= '0;
      chk_q    <= '0;
      status_q <= 1'b1;
    end else begin
      pend_lo  <= pend_lo_n;
      pend_hi  <= pend_hi_n;
      pend_chk <= pend_chk_n;
      if (complete) begin
        data_q <= {pend_hi_n, pend_lo_n};
        chk_q  <= pend_chk_n;
        mask   <= '0;
      end else begin
        mask   <= mask_n;
      end
      if (send_done)                status_q <= 1'b1;
      else if (complete && enable)  status_q <= 1'b0;
    end
  end

  AST_NO_WR_WHILE_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |-> !sending); // R10
  AST_SET_AFTER_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    send_done |=> status_q); // R8
  AST_CLR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_q) |-> $past(enable) && $past(wr_hit)); // R8
  AST_DATA_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_q) |-> $past(wr_hit)); // R2
endmodule

// File: rtl/wss_bit_seq.sv
module wss_bit_seq
  import wss_pkg::*;
#(
  parameter int                 RUNIN_W   = 8,
  parameter logic [RUNIN_W-1:0] RUNIN_PAT = 8'h55,
  parameter int                 START_W   = 4,
  parameter logic [START_W-1:0] START_PAT = 4'b1001,
  parameter int                 BIT_CYC   = 4,
  parameter int                 LN_W      = 10,
  parameter int                 LINE_A    = 20,
  parameter int                 LINE_B    = 283
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic [LN_W-1:0]   line_num,
  input  logic [1:0]        line_en,
  input  logic              std_ntsc,
  input  logic [DATA_W-1:0] data0,
  input  logic [CHK_W-1:0]  chk0,
  input  logic [DATA_W-1:0] data1,
  input  logic [CHK_W-1:0]  chk1,
  output logic              busy,
  output logic              cur_line,
  output logic              std_q,
  output logic              bit_out,
  output logic              done
);
  localparam int FW   = RUNIN_W + START_W + DATA_W + CHK_W;
  localparam int NW   = $clog2(FW + 1);
  localparam int CYW  = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1;
  localparam logic [NW-1:0]  LEN_NTSC = NW'(FW);
  localparam logic [NW-1:0]  LEN_PAL  = NW'(FW - CHK_W);
  localparam logic [CYW-1:0] CYC_LAST = CYW'(BIT_CYC - 1);

  logic [FW-1:0]  sreg;
  logic [NW-1:0]  bitcnt, len;
  logic [CYW-1:0] cyc;
  logic           hit0, hit1, last;

  assign hit0 = line_start && (line_num == LN_W'(LINE_A)) && line_en[0];
  assign hit1 = line_start && (line_num == LN_W'(LINE_B)) && line_en[1];
  assign last = (bitcnt == len - NW'(1));
  assign done = busy && (cyc == CYC_LAST) && last;
  assign bit_out = busy && sreg[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cur_line <= 1'b0;
      std_q    <= 1'b0;
      sreg     <= '0;
      bitcnt   <= '0;
      len      <= '0;
      cyc      <= '0;
    end else if (!busy) begin
      if (hit0 || hit1) begin
        busy     <= 1'b1;
        cur_line <= !hit0;
        std_q    <= std_ntsc;
        sreg     <= hit0 ? {chk0, data0, START_PAT, RUNIN_PAT}
                         : {chk1, data1, START_PAT, RUNIN_PAT};
        len      <= std_ntsc ? LEN_NTSC : LEN_PAL;
        bitcnt   <= '0;
        cyc      <= '0;
      end
    end else if (cyc == CYC_LAST) begin
      cyc <= '0;
      if (last) begin
        busy <= 1'b0;
      end else begin
        sreg   <= sreg >> 1;
        bitcnt <= bitcnt + NW'(1);
      end
    end else begin
      cyc <= cyc + CYW'(1);
    end
  end

  AST_START_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(line_start)); // R4
  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && (cyc != '0) |-> $stable(bit_out)); // R5
  AST_LEN_BY_STD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(bitcnt) == (std_q ? LEN_NTSC : LEN_PAL) - NW'(1)); // R6
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bit_out); // R7
endmodule

// File: rtl/wss_serializer.sv
module wss_serializer
  import wss_pkg::*;
#(
  parameter int                 RUNIN_W   = 8,
  parameter logic [RUNIN_W-1:0] RUNIN_PAT = 8'h55,
  parameter int                 START_W   = 4,
  parameter logic [START_W-1:0] START_PAT = 4'b1001,
  parameter int                 BIT_CYC   = 4,
  parameter int                 LINE_A    = 20,
  parameter int                 LINE_B    = 283,
  parameter logic [7:0]         HI_NTSC   = 8'd140,
  parameter logic [7:0]         HI_PAL    = 8'd143
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic       wr_line,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic       frame_start,
  input  logic [1:0] line_en,
  input  logic       line_start,
  input  logic [9:0] line_num,
  input  logic       std_ntsc,
  output logic       active,
  output logic       bit_out,
  output logic [7:0] lvl_code,
  output logic [1:0] status
);
  localparam int NLINES = 2;

  logic [DATA_W-1:0] data_a [NLINES];
  logic [CHK_W-1:0]  chk_a  [NLINES];
  logic busy, cur_line, std_q, done, bit_s;

  assign wr_ready = !(busy && (cur_line == wr_line));

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    wss_line_store u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_hit     (wr_valid && wr_ready && (wr_line == 1'(g))),
      .wr_sel     (wr_sel),
      .wr_data    (wr_data),
      .frame_start(frame_start),
      .enable     (line_en[g]),
      .sending    (busy && (cur_line == 1'(g))),
      .send_done  (done && (cur_line == 1'(g))),
      .data_q     (data_a[g]),
      .chk_q      (chk_a[g]),
      .status_q   (status[g])
    );
  end

  wss_bit_seq #(
    .RUNIN_W(RUNIN_W), .RUNIN_PAT(RUNIN_PAT), .START_W(START_W),
    .START_PAT(START_PAT), .BIT_CYC(BIT_CYC), .LN_W(10),
    .LINE_A(LINE_A), .LINE_B(LINE_B)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_start(line_start),
    .line_num  (line_num),
    .line_en   (line_en),
    .std_ntsc  (std_ntsc),
    .data0     (data_a[0]),
    .chk0      (chk_a[0]),
    .data1     (data_a[1]),
    .chk1      (chk_a[1]),
    .busy      (busy),
    .cur_line  (cur_line),
    .std_q     (std_q),
    .bit_out   (bit_s),
    .done      (done)
  );

  assign active   = busy;
  assign bit_out  = bit_s;
  assign lvl_code = bit_s ? (std_q ? HI_NTSC : HI_PAL) : 8'd0;

  AST_READY_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |-> active); // R10
  AST_LVL_NONZERO_ON_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    active && bit_out |-> lvl_code != 8'd0); // R7
endmodule

// File: tb/sim_wss_serializer.sv
module sim_wss_serializer;
  localparam int CLK_NS  = 10;
  localparam int BIT_CYC = 4;
  localparam int LINE_A  = 20;
  localparam int LINE_B  = 283;
  localparam logic [7:0] RUNIN = 8'h55;
  localparam logic [3:0] START = 4'b1001;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, wr_line = 0, frame_start = 0, line_start = 0, std_ntsc = 1;
  logic [1:0] wr_sel = 0, line_en = 0;
  logic [7:0] wr_data = 0;
  logic [9:0] line_num = 0;
  logic wr_ready, active, bit_out;
  logic [7:0] lvl_code;
  logic [1:0] status;

  int n_tests = 0, n_fail = 0;
  int exp_q[$];
  string cur_req = "R5";

  always #(CLK_NS/2) clk = ~clk;

  wss_serializer #(.RUNIN_W(8), .RUNIN_PAT(RUNIN), .START_W(4), .START_PAT(START),
    .BIT_CYC(BIT_CYC), .LINE_A(LINE_A), .LINE_B(LINE_B)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_line(wr_line), .wr_sel(wr_sel), .wr_data(wr_data), .frame_start(frame_start),
    .line_en(line_en), .line_start(line_start), .line_num(line_num),
    .std_ntsc(std_ntsc), .active(active), .bit_out(bit_out),
    .lvl_code(lvl_code), .status(status));

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops one expected level code per active cycle
  always @(negedge clk) begin
    if (rst_n && active) begin
      if (exp_q.size() == 0) check({cur_req, " unexpected output"}, 1, 0);
      else check(cur_req, lvl_code, exp_q.pop_front());
    end
  end

  task automatic push_bit(bit b, bit ntsc);
    for (int c = 0; c < BIT_CYC; c++) exp_q.push_back(b ? (ntsc ? 140 : 143) : 0);
  endtask

  // driver: queue the expected stream of one line
  task automatic push_line(logic [13:0] d, logic [5:0] k, bit ntsc);
    for (int i = 0; i < 8; i++)  push_bit(RUNIN[i], ntsc);
    for (int i = 0; i < 4; i++)  push_bit(START[i], ntsc);
    for (int i = 0; i < 14; i++) push_bit(d[i], ntsc);
    if (ntsc) for (int i = 0; i < 6; i++) push_bit(k[i], ntsc);
  endtask

  task automatic wr(bit ln, logic [1:0] sel, logic [7:0] dat);
    @(negedge clk);
    wr_line = ln;
    #1;
    while (!wr_ready) begin @(negedge clk); #1; end
    wr_valid = 1; wr_sel = sel; wr_data = dat;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
  endtask

  task automatic trigger(int ln);
    @(negedge clk); line_num = 10'(ln); line_start = 1;
    @(negedge clk); line_start = 0;
  endtask

  task automatic send_line(string req, int ln, logic [13:0] d, logic [5:0] k, bit ntsc);
    cur_req = req;
    std_ntsc = ntsc;
    push_line(d, k, ntsc);
    trigger(ln);
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    check({req, " active after end"}, active, 0);
  endtask

  task automatic expect_silence(string req, int ln);
    cur_req = req;
    trigger(ln);
    repeat (10) @(negedge clk);
    check(req, active, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++; n_tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 status", status, 3);
    check("R1 active", active, 0);
    check("R1 lvl", lvl_code, 0);
    check("R1 ready", wr_ready, 1);
    line_en = 2'b01;
    send_line("R1 zero data", LINE_A, 14'h0, 6'h0, 1);
    check("R1 status kept", status[0], 1);

    // R2 any order, commit on third byte
    wr(0, 2'd2, 8'h2D);
    wr(0, 2'd1, 8'h25);
    check("R2 partial status", status[0], 1);
    wr(0, 2'd0, 8'hC3);
    check("R8 status cleared", status[0], 0);
    send_line("R5 R6 ntsc", LINE_A, 14'h25C3, 6'h2D, 1);
    check("R8 status set after send", status[0], 1);
    send_line("R9 resend", LINE_A, 14'h25C3, 6'h2D, 1);
    send_line("R7 R6 pal", LINE_A, 14'h25C3, 6'h2D, 0);

    // R3 partial set dropped at frame boundary
    wr(0, 2'd0, 8'h11);
    wr(0, 2'd1, 8'h3A);
    pulse_frame();
    wr(0, 2'd2, 8'h07);
    check("R3 no commit", status[0], 1);
    send_line("R3 old data", LINE_A, 14'h25C3, 6'h2D, 1);
    wr(0, 2'd1, 8'h0F);
    wr(0, 2'd0, 8'h81);
    check("R3 new set commit", status[0], 0);
    send_line("R3 new data", LINE_A, 14'h0F81, 6'h07, 1);

    // R8 disabled line: load accepted, status held
    wr(1, 2'd0, 8'hA5);
    wr(1, 2'd2, 8'h3C);
    wr(1, 2'd1, 8'h16);
    check("R8 disabled keeps status", status[1], 1);
    expect_silence("R4 disabled line", LINE_B);
    expect_silence("R4 wrong line", 100);
    line_en = 2'b11;
    expect_silence("R4 other line number", LINE_A + 1);
    send_line("R4 line B", LINE_B, 14'h16A5, 6'h3C, 1);

    // R10 ready per line, sel 3 ignored
    wr(1, 2'd3, 8'hFF);
    cur_req = "R10 busy";
    push_line(14'h0F81, 6'h07, 1);
    trigger(LINE_A);
    repeat (3) @(negedge clk);
    wr_line = 0; #1;
    check("R10 ready busy line", wr_ready, 0);
    wr_line = 1; #1;
    check("R10 ready other line", wr_ready, 1);
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    check("R10 idle ready", wr_ready, 1);
    send_line("R10 sel3 ignored", LINE_B, 14'h16A5, 6'h3C, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule